// File: doc/BRIEF.md
# Dual FIFO with Threshold Interrupts

This block keeps two byte queues of 128 entries each. One carries outgoing words, the other incoming words. A producer pushes into each queue and a consumer pops from it. A small register port lets a host do three things: set a fill threshold for each direction, read the current word count of each queue, and read a status register whose interrupt bits are sticky.

The transmit side signals when its count falls to or below its threshold, which tells the host that room is free. The receive side signals when its count rises to or above its threshold, which tells the host that a block of words is ready. Each threshold is a 4-bit field multiplied by eight. Each direction also records a push that was dropped because its queue was full.

Top module: `fifo_pair_trig`

## Requirements
- R1: After reset the trigger register reads 0xFF, both level registers read 0, irq_rx is 0, and irq_tx rises one clock after reset is released, because the empty transmit queue is at or below its threshold.
- R2: Each queue holds up to 128 words. Words pop out in the order they were pushed, and pop data is valid on the clock after the pop.
- R3: A push to a full queue that has no pop in the same cycle is dropped and the count stays at 128. Status bit 5 (transmit) or bit 6 (receive) then sets within two clocks.
- R4: A pop from an empty queue leaves the count at 0 and the pop data output unchanged.
- R5: A push and a pop in the same cycle on a queue that is not empty leave its count unchanged, including when the queue is full.
- R6: The trigger register at address 0x10 is read/write. Bits 7:4 hold the receive field and bits 3:0 hold the transmit field. Each threshold is eight times its field.
- R7: Address 0x11 reads the transmit word count and address 0x12 reads the receive word count.
- R8: The receive flag (status bit 3, output irq_rx) sets one clock after the receive count is at or above its threshold.
- R9: The transmit flag (status bit 4, output irq_tx) sets one clock after the transmit count is at or below its threshold.
- R10: Flags are sticky. A read of the status register at address 0x02 clears each bit whose condition does not hold in that cycle.
- R11: reg_rdata is valid on the clock after reg_rd. Unmapped addresses read 0x00, and writes to read-only addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| tx_push | input | 1 | Push into transmit queue |
| tx_push_data | input | 8 | Word to push into transmit queue |
| tx_pop | input | 1 | Pop from transmit queue |
| tx_pop_data | output | 8 | Word popped from transmit queue |
| rx_push | input | 1 | Push into receive queue |
| rx_push_data | input | 8 | Word to push into receive queue |
| rx_pop | input | 1 | Pop from receive queue |
| rx_pop_data | output | 8 | Word popped from receive queue |
| irq_tx | output | 1 | Sticky transmit threshold flag |
| irq_rx | output | 1 | Sticky receive threshold flag |

## Verification
A wrong count shows at the level registers on the clock after the read strobe. It shows at the flags one clock after the threshold should have been crossed, since each flag sits one register behind the count. A pointer that is off by one shows up as out-of-order pop data on the first pop after the fault. A flag that fails to hold or fails to clear on a status read is seen at irq_rx or irq_tx on the next clock.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  localparam int REG_W = 8;
  localparam logic [7:0] ADDR_STAT  = 8'h02;
  localparam logic [7:0] ADDR_TRIG  = 8'h10;
  localparam logic [7:0] ADDR_TXLVL = 8'h11;
  localparam logic [7:0] ADDR_RXLVL = 8'h12;
  localparam int BIT_RX_FLAG = 3;
  localparam int BIT_TX_FLAG = 4;
  localparam int BIT_TX_OVF  = 5;
  localparam int BIT_RX_OVF  = 6;
  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;
endpackage

// File: rtl/fpt_fifo.sv
module fpt_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W-1:0]  count,
  output logic              overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_push, do_pop, is_full, is_empty;

  assign is_full  = (count == CNT_FULL);
  assign is_empty = (count == '0);
  assign do_pop   = pop && !is_empty;
  assign do_push  = push && (!is_full || do_pop);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      pop_data <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= push && !do_push;
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop) begin
        rd_ptr   <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
        pop_data <= mem[rd_ptr];
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_FULL);
  assert_pair_keeps_count_R5: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !is_empty) |=> (count == $past(count)));
  assert_empty_pop_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && is_empty) |=> (count == '0 && $stable(pop_data)));
  assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && is_full) |=> (count == CNT_FULL && overflow));
endmodule

// File: rtl/fpt_trig_irq.sv
module fpt_trig_irq #(
  parameter int CNT_W   = 8,
  parameter int TRIG_W  = 4,
  parameter int SCALE   = 8,
  parameter bit FILL_UP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  count,
  input  logic [TRIG_W-1:0] field,
  input  logic              clr,
  output logic              flag
);
  logic [31:0] thr;
  logic        hit;

  assign thr = 32'(field) * 32'(SCALE);

  generate
    if (FILL_UP) begin : g_rise
      assign hit = (32'(count) >= thr);
    end else begin : g_fall
      assign hit = (32'(count) <= thr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R8 on the receive instance, R9 on the transmit instance
  assert_level_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/fifo_pair_trig.sv
module fifo_pair_trig #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int TRIG_W = 4,
  parameter int SCALE  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_push_data,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_pop_data,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_push_data,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_pop_data,
  output logic              irq_tx,
  output logic              irq_rx
);
  import fpt_pkg::*;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int TRIGR_W = 2 * TRIG_W;

  logic [TRIGR_W-1:0] trig_q;
  logic [1:0]         push_v, pop_v, ovf_v, flag_v, ovf_q;
  logic [DATA_W-1:0]  push_d [2];
  logic [DATA_W-1:0]  pop_d  [2];
  logic [CNT_W-1:0]   cnt    [2];
  logic [REG_W-1:0]   status;
  logic               stat_rd;

  assign push_v = {rx_push, tx_push};
  assign pop_v  = {rx_pop, tx_pop};
  assign push_d[DIR_TX] = tx_push_data;
  assign push_d[DIR_RX] = rx_push_data;
  assign tx_pop_data = pop_d[DIR_TX];
  assign rx_pop_data = pop_d[DIR_RX];
  assign irq_tx = flag_v[DIR_TX];
  assign irq_rx = flag_v[DIR_RX];
  assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);

  for (genvar g = 0; g < 2; g++) begin : g_dir
    fpt_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
      .clk(clk), .rst(rst), .push(push_v[g]), .push_data(push_d[g]),
      .pop(pop_v[g]), .pop_data(pop_d[g]), .count(cnt[g]), .overflow(ovf_v[g]));
    fpt_trig_irq #(.CNT_W(CNT_W), .TRIG_W(TRIG_W), .SCALE(SCALE),
                   .FILL_UP(g == int'(DIR_RX))) u_irq (
      .clk(clk), .rst(rst), .count(cnt[g]), .field(trig_q[g*TRIG_W +: TRIG_W]),
      .clr(stat_rd), .flag(flag_v[g]));
  end

  always_comb begin
    status = '0;
    status[BIT_RX_FLAG] = flag_v[DIR_RX];
    status[BIT_TX_FLAG] = flag_v[DIR_TX];
    status[BIT_TX_OVF]  = ovf_q[DIR_TX];
    status[BIT_RX_OVF]  = ovf_q[DIR_RX];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q    <= '1;
      ovf_q     <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_TRIG) trig_q <= reg_wdata[TRIGR_W-1:0];
      for (int i = 0; i < 2; i++) begin
        if (ovf_v[i])     ovf_q[i] <= 1'b1;
        else if (stat_rd) ovf_q[i] <= 1'b0;
      end
      if (reg_rd) begin
        case (reg_addr)
          ADDR_STAT:  reg_rdata <= status;
          ADDR_TRIG:  reg_rdata <= REG_W'(trig_q);
          ADDR_TXLVL: reg_rdata <= REG_W'(cnt[DIR_TX]);
          ADDR_RXLVL: reg_rdata <= REG_W'(cnt[DIR_RX]);
          default:    reg_rdata <= '0;
        endcase
      end
    end
  end

  assert_trig_write_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_TRIG) |=> (trig_q == $past(reg_wdata[TRIGR_W-1:0])));
  assert_txlvl_read_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_TXLVL) |=> (reg_rdata == REG_W'($past(cnt[DIR_TX]))));
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (ovf_v[DIR_TX] && !$past(rst)) |=> ovf_q[DIR_TX]);
endmodule

// File: tb/sim_fifo_pair_trig.sv
`timescale 1ns/1ps
module sim_fifo_pair_trig;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_push_data = '0, rx_push_data = '0, tx_pop_data, rx_pop_data;
  logic irq_tx, irq_rx;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fifo_pair_trig u0 (.*);

  // {expected irq_rx, rx field, words pushed}
  localparam logic [12:0] VEC [0:5] = '{
    {1'b0, 4'd2, 8'd15}, {1'b1, 4'd2, 8'd16}, {1'b1, 4'd0, 8'd0},
    {1'b0, 4'd15, 8'd119}, {1'b1, 4'd15, 8'd120}, {1'b1, 4'd1, 8'd9}};

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a; tick(); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic txpush(logic [7:0] d);
    tx_push = 1'b1; tx_push_data = d; tick(); tx_push = 1'b0;
  endtask

  task automatic txpop(); tx_pop = 1'b1; tick(); tx_pop = 1'b0; endtask

  task automatic rxpush(logic [7:0] d);
    rx_push = 1'b1; rx_push_data = d; tick(); rx_push = 1'b0;
  endtask

  task automatic rxpop(); rx_pop = 1'b1; tick(); rx_pop = 1'b0; endtask

  task automatic rx_drain_clear();
    logic [7:0] v;
    rd(8'h12, v);
    repeat (int'(v)) rxpop();
    rd(8'h02, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    rd(8'h10, v); chk("R1 trig reset", v, 8'hFF);
    rd(8'h11, v); chk("R1 tx level reset", v, 0);
    rd(8'h12, v); chk("R1 rx level reset", v, 0);
    chk("R1 irq_rx reset", irq_rx, 0);
    chk("R1 irq_tx after reset", irq_tx, 1);

    // R6 R8 table of thresholds
    for (int i = 0; i < 6; i++) begin
      wr(8'h10, {VEC[i][11:8], 4'hF});
      rd(8'h10, v); chk("R6 trig readback", v, {VEC[i][11:8], 4'hF});
      rx_drain_clear();
      for (int k = 0; k < int'(VEC[i][7:0]); k++) rxpush(8'(k));
      tick();
      chk("R8 rx threshold", irq_rx, VEC[i][12]);
    end

    // R9 R2 transmit threshold and order (tx threshold 8)
    wr(8'h10, 8'h01);
    for (int k = 0; k < 10; k++) txpush(8'(k + 16));
    rd(8'h11, v); chk("R7 tx level", v, 10);
    rd(8'h02, v); rd(8'h02, v);
    chk("R9 tx flag clear above thr", v[4], 0);
    chk("R9 irq_tx low above thr", irq_tx, 0);
    txpop(); chk("R2 first pop data", tx_pop_data, 16);
    txpop(); chk("R2 second pop data", tx_pop_data, 17);
    tick(); chk("R9 irq_tx at thr", irq_tx, 1);
    repeat (8) txpop();
    chk("R2 last pop data", tx_pop_data, 25);

    // R4 pop from empty
    txpop();
    chk("R4 empty pop data held", tx_pop_data, 25);
    rd(8'h11, v); chk("R4 empty pop count", v, 0);

    // R3 overflow, R5 pair at full
    for (int k = 0; k < 128; k++) txpush(8'(k));
    rd(8'h11, v); chk("R2 capacity", v, 128);
    txpush(8'hAA);
    tick();
    rd(8'h11, v); chk("R3 count after drop", v, 128);
    rd(8'h02, v); chk("R3 tx overflow bit5", v[5], 1);
    rd(8'h02, v); chk("R10 overflow cleared on read", v[5], 0);
    tx_push = 1'b1; tx_pop = 1'b1; tx_push_data = 8'h55; tick();
    tx_push = 1'b0; tx_pop = 1'b0;
    chk("R2 pop at full data", tx_pop_data, 0);
    rd(8'h11, v); chk("R5 pair keeps count", v, 128);
    rd(8'h02, v); chk("R5 pair no overflow", v[5], 0);

    // R11 read-only and unmapped
    wr(8'h11, 8'h00);
    rd(8'h11, v); chk("R11 write to level ignored", v, 128);
    rd(8'h05, v); chk("R11 unmapped read", v, 0);

    // R10 sticky receive flag (rx threshold 8)
    wr(8'h10, 8'h1F);
    rx_drain_clear();
    for (int k = 0; k < 8; k++) rxpush(8'(k + 64));
    tick(); chk("R8 irq_rx at 8", irq_rx, 1);
    rxpop(); chk("R2 rx pop data", rx_pop_data, 64);
    tick(); chk("R10 irq_rx held below thr", irq_tx | irq_rx, 1);
    chk("R10 irq_rx sticky", irq_rx, 1);
    rd(8'h02, v); chk("R10 status bit3", v[3], 1);
    chk("R10 irq_rx cleared by read", irq_rx, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule